// File: doc/BRIEF.md
# DRAM Row Column Bank Mapper

This block turns a rank-local memory address into the DRAM coordinates a channel controller drives: row, column, bank address and bank group. Row and column bits are not taken as contiguous slices. Each output bit is gathered from a fixed, scattered address bit. The gathering pattern depends on the page policy: close-page, plain open-page, or open-page with fine-grain bank interleave. Bank and bank-group bits can be hashed with higher address bits. In close-page mode the auto-precharge column bit is forced high.

The per-DIMM setup is captured from a single descriptor word on a load strobe, together with a separate fine-grain flag. The captured setup is held until the next load. The descriptor is range-checked. A missing DIMM or a field outside its legal range raises a configuration error, and that error blocks the output valid flag. The mapping itself is combinational. A parameter adds an output register, which costs one cycle of latency.

Top module: `dram_rcb_mapper`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `cfg_err_o` is 1, because no DIMM is loaded.
- R2: When `cfg_load_i` is high at a clock edge, the descriptor is captured and held until the next load. The descriptor fields are:
  - bit 15: DIMM present;
  - bit 0: close-page;
  - bit 9: bank hash enable;
  - bits [13:12]: rank count;
  - bits [4:2]: row field, giving row bit count = field + 12;
  - bits [1:0]: column field, giving column bit count = field + 10.
  
  `cfg_fine_i` is captured with the descriptor as the fine-grain flag.
- R3: `cfg_err_o` is 1 when any of these holds: bit 15 is 0, the rank field is outside 1..2, the row field is outside 1..6, or the column field is above 2. While `cfg_err_o` is 1, no lookup raises `out_valid_o`.
- R4: In close-page mode, row bit i is address bit `{15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33}[i]`.
- R5: In close-page mode, column bit i is address bit `{3,4,5,14,19,23,24,25,26,27}[i]`, and column bit 10 is always 1.
- R6: In open-page mode, row bit i is address bit `{14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33}[i]`.
- R7: In open-page mode, column bit i is address bit 3+i. With the fine-grain flag set, it is instead `{3,4,5,7,8,9,10,11,12,13}[i]`.
- R8: In close-page mode, the bank is {a9,a8} and the bank group is {a7,a6}. When hashing is enabled, these are XORed with {a28,a22} and {a21,a20} respectively.
- R9: In open-page mode, the bank is {a19,a18}, XORed with {a23,a22} when hashing is enabled. The bank group is {a17,g}, XORed with {a21,a20} when hashing is enabled, where g is a6 with the fine-grain flag and a13 without it.
- R10: Only the configured number of row and column bits are gathered. Positions beyond the configured count, or beyond the end of a pattern, read 0.
- R11: With the output register (default), a lookup with `in_valid_i` high at one edge presents its result with `out_valid_o` = 1 after that edge. `out_valid_o` returns to 0 after an edge with `in_valid_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load_i | input | 1 | Capture descriptor and fine-grain flag |
| cfg_word_i | input | 32 | DIMM descriptor word |
| cfg_fine_i | input | 1 | Fine-grain bank interleave flag |
| in_valid_i | input | 1 | Lookup request |
| addr_i | input | ADDR_W (34) | Rank-local address |
| out_valid_o | output | 1 | Result valid |
| cfg_err_o | output | 1 | Descriptor missing or out of range |
| row_o | output | ROW_W (18) | DRAM row |
| col_o | output | COL_W (12) | DRAM column |
| bank_o | output | 2 | Bank address |
| bgroup_o | output | 2 | Bank group |

## Verification
The hardest situation to reach is a set of full-width row and column gathers whose upper positions run past the end of the bit patterns. That needs a row field of 6 and a column field of 2, where column field bit 0 is also the close-page flag. The stimulus builds descriptors covering every page policy crossed with hash on and off, including the largest and smallest legal counts. For each descriptor it pushes random addresses and compares the outputs against a table-driven model. Illegal descriptors, each with a single bad field, are then loaded, and a lookup is issued to confirm the valid flag stays low.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;

  localparam int CNT_W = 6;

  typedef enum logic [1:0] {
    MODE_OPEN  = 2'd0,
    MODE_CLOSE = 2'd1,
    MODE_FINE  = 2'd2
  } map_mode_e;

  typedef struct packed {
    logic             present;
    logic             close_pg;
    logic             hash_en;
    logic             fine;
    logic [CNT_W-1:0] row_n;
    logic [CNT_W-1:0] col_n;
    logic             err;
  } dimm_cfg_t;

  // descriptor field positions (decoded by the neighbour that writes them)
  localparam int F_PRESENT = 15;
  localparam int F_CLOSE   = 0;
  localparam int F_HASH    = 9;
  localparam int F_RANK_LO = 12;
  localparam int F_ROW_LO  = 2;
  localparam int F_COL_LO  = 0;
  localparam int ROW_BASE  = 12;
  localparam int COL_BASE  = 10;

  localparam int ROW_T_LEN = 17;
  localparam int COL_T_LEN = 10;

  localparam int ROW_CLOSE_T [ROW_T_LEN] =
    '{15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33};
  localparam int ROW_OPEN_T  [ROW_T_LEN] =
    '{14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33};
  localparam int COL_CLOSE_T [COL_T_LEN] = '{3,4,5,14,19,23,24,25,26,27};
  localparam int COL_FINE_T  [COL_T_LEN] = '{3,4,5,7,8,9,10,11,12,13};

  // source address bit for output bit i, -1 when the pattern has none
  function automatic int src_index(int is_row, int mode, int i);
    if (is_row != 0) begin
      if (i >= ROW_T_LEN) return -1;
      return (mode == 1) ? ROW_CLOSE_T[i] : ROW_OPEN_T[i];
    end
    if (i >= COL_T_LEN) return -1;
    if (mode == 1) return COL_CLOSE_T[i];
    if (mode == 2) return COL_FINE_T[i];
    return 3 + i;
  endfunction

  function automatic logic [1:0] pair_bits(logic [63:0] a, int lo, int hi,
                                           int xlo, int xhi, logic hx);
    logic [1:0] r;
    r = {a[hi], a[lo]};
    if (hx) r = r ^ {a[xhi], a[xlo]};
    return r;
  endfunction

endpackage

// File: rtl/dimm_cfg_reg.sv
module dimm_cfg_reg
  import dram_map_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [31:0] word_i,
  input  logic        fine_i,
  output dimm_cfg_t   cfg_o
);

  logic [1:0] rank_f;
  logic [2:0] row_f;
  logic [1:0] col_f;
  logic       bad_field;
  dimm_cfg_t  nxt;
  dimm_cfg_t  cfg_q;
  logic       unused_bits;

  assign rank_f = word_i[F_RANK_LO +: 2];
  assign row_f  = word_i[F_ROW_LO +: 3];
  assign col_f  = word_i[F_COL_LO +: 2];
  assign unused_bits = ^{word_i[31:16], word_i[14], word_i[11:10], word_i[8:5]};

  assign bad_field = (rank_f < 2'd1) || (rank_f > 2'd2) ||
                     (row_f < 3'd1)  || (row_f > 3'd6)  ||
                     (col_f > 2'd2);

  always_comb begin
    nxt.present  = word_i[F_PRESENT];
    nxt.close_pg = word_i[F_CLOSE];
    nxt.hash_en  = word_i[F_HASH];
    nxt.fine     = fine_i;
    nxt.row_n    = CNT_W'(row_f) + CNT_W'(ROW_BASE);
    nxt.col_n    = CNT_W'(col_f) + CNT_W'(COL_BASE);
    nxt.err      = !word_i[F_PRESENT] || bad_field;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cfg_q.err <= 1'b1;
    end else if (load_i) begin
      cfg_q <= nxt;
    end
  end

  assign cfg_o = cfg_q;

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/addr_gather.sv
module addr_gather
  import dram_map_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int NOUT   = 18,
  parameter int IS_ROW = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  map_mode_e         mode_i,
  output logic [NOUT-1:0]   bits_o
);

  for (genvar i = 0; i < NOUT; i++) begin : g_bit
    localparam int S_OPEN  = src_index(IS_ROW, 0, i);
    localparam int S_CLOSE = src_index(IS_ROW, 1, i);
    localparam int S_FINE  = src_index(IS_ROW, 2, i);
    logic b_open, b_close, b_fine, picked;

    if (S_OPEN >= 0 && S_OPEN < ADDR_W) begin : g_o
      assign b_open = addr_i[S_OPEN];
    end else begin : g_on
      assign b_open = 1'b0;
    end
    if (S_CLOSE >= 0 && S_CLOSE < ADDR_W) begin : g_c
      assign b_close = addr_i[S_CLOSE];
    end else begin : g_cn
      assign b_close = 1'b0;
    end
    if (S_FINE >= 0 && S_FINE < ADDR_W) begin : g_f
      assign b_fine = addr_i[S_FINE];
    end else begin : g_fn
      assign b_fine = 1'b0;
    end

    always_comb begin
      unique case (mode_i)
        MODE_CLOSE: picked = b_close;
        MODE_FINE:  picked = b_fine;
        default:    picked = b_open;
      endcase
    end

    assign bits_o[i] = (CNT_W'(i) < cnt_i) ? picked : 1'b0;
  end

endmodule

// File: rtl/bank_hash.sv
module bank_hash
  import dram_map_pkg::*;
#(
  parameter int ADDR_W = 34
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              close_i,
  input  logic              hash_i,
  input  logic              fine_i,
  output logic [1:0]        bank_o,
  output logic [1:0]        bgroup_o
);

  localparam int BG_FINE_SRC  = 6;
  localparam int BG_PLAIN_SRC = 13;

  always_comb begin
    if (close_i) begin
      bank_o   = pair_bits(64'(addr_i), 8, 9, 22, 28, hash_i);
      bgroup_o = pair_bits(64'(addr_i), 6, 7, 20, 21, hash_i);
    end else begin
      bank_o   = pair_bits(64'(addr_i), 18, 19, 22, 23, hash_i);
      bgroup_o = pair_bits(64'(addr_i), fine_i ? BG_FINE_SRC : BG_PLAIN_SRC,
                           17, 20, 21, hash_i);
    end
  end

endmodule

// File: rtl/dram_rcb_mapper.sv
module dram_rcb_mapper
  import dram_map_pkg::*;
#(
  parameter int ADDR_W  = 34,
  parameter int ROW_W   = 18,
  parameter int COL_W   = 12,
  parameter int AP_BIT  = 10,
  parameter int OUT_REG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load_i,
  input  logic [31:0]       cfg_word_i,
  input  logic              cfg_fine_i,
  input  logic              in_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              out_valid_o,
  output logic              cfg_err_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [1:0]        bank_o,
  output logic [1:0]        bgroup_o
);

  localparam logic [COL_W-1:0] AP_MASK = COL_W'(1) << AP_BIT;

  dimm_cfg_t  cfg;
  map_mode_e  mode;
  logic [ROW_W-1:0] row_c;
  logic [COL_W-1:0] col_g, col_c;
  logic [1:0] bank_c, bg_c;
  logic       vld_c;
  logic       st_close;
  logic [CNT_W-1:0] st_rown;

  dimm_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(cfg_load_i),
    .word_i(cfg_word_i), .fine_i(cfg_fine_i), .cfg_o(cfg)
  );

  assign mode = cfg.close_pg ? MODE_CLOSE : (cfg.fine ? MODE_FINE : MODE_OPEN);

  addr_gather #(.ADDR_W(ADDR_W), .NOUT(ROW_W), .IS_ROW(1)) u_row (
    .addr_i(addr_i), .cnt_i(cfg.row_n), .mode_i(mode), .bits_o(row_c)
  );

  addr_gather #(.ADDR_W(ADDR_W), .NOUT(COL_W), .IS_ROW(0)) u_col (
    .addr_i(addr_i), .cnt_i(cfg.col_n), .mode_i(mode), .bits_o(col_g)
  );

  bank_hash #(.ADDR_W(ADDR_W)) u_bank (
    .addr_i(addr_i), .close_i(cfg.close_pg), .hash_i(cfg.hash_en),
    .fine_i(cfg.fine), .bank_o(bank_c), .bgroup_o(bg_c)
  );

  assign col_c     = cfg.close_pg ? (col_g | AP_MASK) : col_g;
  assign vld_c     = in_valid_i && !cfg.err;
  assign cfg_err_o = cfg.err;

  if (OUT_REG != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid_o <= 1'b0;
        row_o       <= '0;
        col_o       <= '0;
        bank_o      <= '0;
        bgroup_o    <= '0;
        st_close    <= 1'b0;
        st_rown     <= '0;
      end else begin
        out_valid_o <= vld_c;
        if (vld_c) begin
          row_o    <= row_c;
          col_o    <= col_c;
          bank_o   <= bank_c;
          bgroup_o <= bg_c;
          st_close <= cfg.close_pg;
          st_rown  <= cfg.row_n;
        end
      end
    end

    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |=> !out_valid_o); // R3
  end else begin : g_comb
    assign out_valid_o = vld_c;
    assign row_o       = row_c;
    assign col_o       = col_c;
    assign bank_o      = bank_c;
    assign bgroup_o    = bg_c;
    assign st_close    = cfg.close_pg;
    assign st_rown     = cfg.row_n;

    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> !out_valid_o); // R3
  end

  AST_ROW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((row_o >> st_rown) == '0)); // R10

  AST_AP_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && st_close) |-> col_o[AP_BIT]); // R5

  AST_NO_REQ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG != 0 && !in_valid_i) |=> !out_valid_o); // R11

endmodule

// File: tb/sim_dram_rcb_mapper.sv
module sim_dram_rcb_mapper;

  localparam int AW = 34;
  localparam int RW = 18;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [31:0] cfg_word = '0;
  logic cfg_fine = 1'b0;
  logic in_valid = 1'b0;
  logic [AW-1:0] addr = '0;
  logic out_valid, cfg_err;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [1:0] bank, bgroup;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dram_rcb_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load), .cfg_word_i(cfg_word),
    .cfg_fine_i(cfg_fine), .in_valid_i(in_valid), .addr_i(addr),
    .out_valid_o(out_valid), .cfg_err_o(cfg_err), .row_o(row), .col_o(col),
    .bank_o(bank), .bgroup_o(bgroup)
  );

  // reference patterns, taken from the requirements
  int rc_t[17] = '{15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33};
  int ro_t[17] = '{14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33};
  int cc_t[10] = '{3,4,5,14,19,23,24,25,26,27};
  int cf_t[10] = '{3,4,5,7,8,9,10,11,12,13};

  // current reference setup
  bit m_close, m_hash, m_fine;
  int m_rows, m_cols;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(bit pres, int ranks, bit hash, int rowf, int colf);
    return (32'(pres) << 15) | (32'(ranks) << 12) | (32'(hash) << 9) |
           (32'(rowf) << 2) | 32'(colf);
  endfunction

  task automatic load(logic [31:0] w, bit fine);
    @(negedge clk);
    cfg_load = 1'b1; cfg_word = w; cfg_fine = fine;
    @(negedge clk);
    cfg_load = 1'b0; cfg_word = $urandom;
    m_close = w[0]; m_hash = w[9]; m_fine = fine;
    m_rows = int'(w[4:2]) + 12; m_cols = int'(w[1:0]) + 10;
  endtask

  task automatic lookup(logic [AW-1:0] a);
    @(negedge clk);
    in_valid = 1'b1; addr = a;
    @(negedge clk);
    in_valid = 1'b0; addr = '0;
  endtask

  function automatic logic [RW-1:0] ref_row(logic [AW-1:0] a);
    logic [RW-1:0] r = '0;
    for (int i = 0; i < m_rows && i < 17; i++)
      r[i] = m_close ? a[rc_t[i]] : a[ro_t[i]];
    return r;
  endfunction

  function automatic logic [CW-1:0] ref_col(logic [AW-1:0] a);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < m_cols && i < 10; i++)
      c[i] = m_close ? a[cc_t[i]] : (m_fine ? a[cf_t[i]] : a[3 + i]);
    if (m_close) c[10] = 1'b1;
    return c;
  endfunction

  function automatic logic [1:0] ref_bank(logic [AW-1:0] a);
    logic [1:0] b;
    if (m_close) b = {a[9], a[8]} ^ (m_hash ? {a[28], a[22]} : 2'b00);
    else         b = {a[19], a[18]} ^ (m_hash ? {a[23], a[22]} : 2'b00);
    return b;
  endfunction

  function automatic logic [1:0] ref_bg(logic [AW-1:0] a);
    logic [1:0] g;
    if (m_close) g = {a[7], a[6]};
    else         g = {a[17], m_fine ? a[6] : a[13]};
    return g ^ (m_hash ? {a[21], a[20]} : 2'b00);
  endfunction

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(cfg_err == 1'b1, "R1 cfg_err after reset", cfg_err, 1);
    lookup(34'h3_0000_0000);
    chk(out_valid == 1'b0, "R1 no valid before load", out_valid, 0);
  endtask

  task automatic t_bad_cfg(logic [31:0] w, string tag);
    load(w, 1'b0);
    chk(cfg_err == 1'b1, tag, cfg_err, 1);
    lookup(34'h1_2345_6789);
    chk(out_valid == 1'b0, "R3 valid blocked", out_valid, 0);
  endtask

  task automatic t_errors();
    t_bad_cfg(mk_word(0, 1, 0, 3, 0), "R3 not present");
    t_bad_cfg(mk_word(1, 0, 0, 3, 0), "R3 ranks=0");
    t_bad_cfg(mk_word(1, 3, 0, 3, 0), "R3 ranks=3");
    t_bad_cfg(mk_word(1, 1, 0, 0, 0), "R3 rowf=0");
    t_bad_cfg(mk_word(1, 2, 0, 7, 0), "R3 rowf=7");
    t_bad_cfg(mk_word(1, 1, 0, 3, 3), "R3 colf=3");
  endtask

  task automatic t_map(logic [31:0] w, bit fine, int n);
    string rt, ct, bt;
    load(w, fine);
    chk(cfg_err == 1'b0, "R2 legal descriptor accepted", cfg_err, 0);
    rt = m_close ? "R4 row close" : "R6 row open";
    ct = m_close ? "R5 col close" : "R7 col open/fine";
    bt = m_close ? "R8 bank close" : "R9 bank open";
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] a;
      a = {$urandom, $urandom};
      if (k == 0) a = '1;
      lookup(a);
      chk(out_valid == 1'b1, "R11 valid one cycle after request", out_valid, 1);
      chk(row == ref_row(a), rt, row, ref_row(a));
      chk(col == ref_col(a), ct, col, ref_col(a));
      chk(bank == ref_bank(a), bt, bank, ref_bank(a));
      chk(bgroup == ref_bg(a), bt, bgroup, ref_bg(a));
      if (k == 0) begin
        chk((row >> m_rows) == 0, "R10 row masked to count", row, ref_row(a));
        chk((col & 12'h3FF & ~((12'h1 << (m_cols > 10 ? 10 : m_cols)) - 12'h1)) == 0,
            "R10 col beyond count", col, ref_col(a));
      end
      @(negedge clk);
      chk(out_valid == 1'b0, "R11 valid drops without request", out_valid, 0);
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] a;
    a = 34'h2_5A5A_C3C3;
    load(mk_word(1, 2, 1, 4, 1), 1'b0);
    repeat (5) @(negedge clk);
    lookup(a);
    chk(row == ref_row(a) && col == ref_col(a), "R2 setup held without load",
        {row, col}, {ref_row(a), ref_col(a)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_errors();
    for (int h = 0; h < 2; h++) begin
      t_map(mk_word(1, 1, h[0], 6, 1), 1'b0, 20); // close, full rows
      t_map(mk_word(1, 2, h[0], 1, 1), 1'b0, 20); // close, min rows
      t_map(mk_word(1, 1, h[0], 6, 2), 1'b0, 20); // open, wide cols
      t_map(mk_word(1, 2, h[0], 3, 0), 1'b0, 20); // open, min cols
      t_map(mk_word(1, 1, h[0], 5, 2), 1'b1, 20); // open fine
      t_map(mk_word(1, 2, h[0], 2, 0), 1'b1, 20); // open fine, narrow
    end
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule